// File: doc/BRIEF.md
# Strobe/Acknowledge Link Protocol Monitor

This block is a passive observer for one point-to-point link that moves a payload word from a transmitter to a receiver under a strobe/acknowledge handshake. It samples the link's synchronous reset, the payload bus, the strobe and the acknowledge on every rising clock edge. It never drives the link. The transmitter raises the strobe when the payload is valid. The receiver raises the acknowledge when it can accept a word. A word moves on every edge where both are sampled high, and both may stay high so that words move on consecutive edges.

The monitor keeps one sticky flag for each class of rule violation: reset behaviour, strobe stability, acknowledge stability, payload stability, and the direction of waiting. It also drives a combined error output and a count of completed transfers. The monitor has its own active-low reset, which is asserted asynchronously and released synchronously. That reset is the only thing that clears the flags and the counter. The link reset it observes is treated only as traffic to check.

Top module: `hs_link_monitor`

## Requirements
- R1: If the observed link reset is sampled 1 on an edge and either the strobe or the acknowledge is sampled 1 on the next edge, flag bit 0 (reset violation) is set on that next edge.
- R2: If the strobe was sampled 1 and the acknowledge 0 on one edge, with the link reset 0, and the strobe is sampled 0 on the next edge, flag bit 1 (strobe dropped) is set on that next edge.
- R3: If the acknowledge was sampled 1 and the strobe 0 on one edge, with the link reset 0, and the acknowledge is sampled 0 on the next edge, flag bit 2 (acknowledge dropped) is set on that next edge.
- R4: If the strobe was sampled 1 and the acknowledge 0 on one edge, with the link reset 0, and on the next edge the strobe is still 1 but the payload differs, flag bit 3 (payload changed) is set on that next edge.
- R5: The payload value has no effect on any flag when the strobe is 0. A payload that changes right after a completed transfer is also legal.
- R6: Every edge with the strobe and the acknowledge both 1 and the link reset 0 adds one to the transfer count on that edge, including transfers on consecutive edges. The count wraps at its width and holds on every other edge.
- R7: If the acknowledge rises on an edge where the strobe is 0 and the link reset is 0, and the strobe is sampled 1 on the next edge, flag bit 4 (transmitter waited) is set on that next edge.
- R8: Every flag stays set until the monitor reset. The combined error output is 1 exactly when any flag is 1.
- R9: While the monitor reset is low and after it is released, all flags, the combined error and the count are 0 until traffic changes them.
- R10: Dropping the strobe or the acknowledge on the edge after a completed transfer sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, rising edge samples |
| rst_n | input | 1 | Monitor reset, active low, asynchronous assert |
| lnk_rst | input | 1 | Observed synchronous link reset, active high |
| lnk_data | input | DATA_W | Observed payload bus |
| lnk_stb | input | 1 | Observed strobe from the transmitter |
| lnk_ack | input | 1 | Observed acknowledge from the receiver |
| err_flags | output | 5 | Sticky flags: 0 reset, 1 strobe, 2 acknowledge, 3 payload, 4 waiting |
| err_any | output | 1 | OR of all sticky flags |
| xfer_cnt | output | CNT_W | Completed transfer count |

## Verification
The properties ask nothing of the link inputs beyond having settled values at each rising edge. A monitor has to accept illegal traffic, so each property relates a flag or count change only to what the link showed on earlier edges, whatever that was. The stimulus changes every input on the falling edge. It interleaves directed violations and legal cases with random traffic that mostly follows the handshake but sometimes drops signals, alters the payload, pulses the link reset, or raises the strobe just after the acknowledge. The monitor is reset often so that the sticky flags do not saturate.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int ERR_N      = 5;
  localparam int E_RST      = 0;
  localparam int E_STB      = 1;
  localparam int E_ACK      = 2;
  localparam int E_DATA     = 3;
  localparam int E_NOWAIT   = 4;
  typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/hs_mon_history.sv
module hs_mon_history #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_rst,
  input  logic [DATA_W-1:0] lnk_data,
  input  logic              lnk_stb,
  input  logic              lnk_ack,
  output logic              h_rst,
  output logic              h_stb,
  output logic              h_ack,
  output logic              h_arm,
  output logic [DATA_W-1:0] h_data
);
  logic              h_rst_d;
  logic              h_stb_d;
  logic              h_ack_d;
  logic              h_arm_d;
  logic              data_en;
  logic [DATA_W-1:0] h_data_d;

  // Next-state: previous-edge view of the link, plus the arm bit that
  // marks an acknowledge rising while the strobe is still low.
  always_comb begin
    h_rst_d  = lnk_rst;
    h_stb_d  = lnk_stb;
    h_ack_d  = lnk_ack;
    h_arm_d  = !lnk_rst && lnk_ack && !h_ack && !lnk_stb;
    data_en  = lnk_stb;
    h_data_d = lnk_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rst <= 1'b0;
      h_stb <= 1'b0;
      h_ack <= 1'b0;
      h_arm <= 1'b0;
    end else begin
      h_rst <= h_rst_d;
      h_stb <= h_stb_d;
      h_ack <= h_ack_d;
      h_arm <= h_arm_d;
    end
  end

  // Payload copy is only read when h_stb is set, so it needs no reset
  // and is only loaded while the strobe is high.
  always_ff @(posedge clk) begin
    if (data_en) begin
      h_data <= h_data_d;
    end
  end
endmodule

// File: rtl/hs_mon_rules.sv
module hs_mon_rules
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              lnk_stb,
  input  logic              lnk_ack,
  input  logic [DATA_W-1:0] lnk_data,
  input  logic              h_rst,
  input  logic              h_stb,
  input  logic              h_ack,
  input  logic              h_arm,
  input  logic [DATA_W-1:0] h_data,
  output err_vec_t          viol
);
  logic live;
  logic stb_pending;
  logic ack_pending;

  always_comb begin
    live        = !h_rst;
    stb_pending = live && h_stb && !h_ack;
    ack_pending = live && h_ack && !h_stb;
    viol           = '0;
    viol[E_RST]    = h_rst && (lnk_stb || lnk_ack);
    viol[E_STB]    = stb_pending && !lnk_stb;
    viol[E_ACK]    = ack_pending && !lnk_ack;
    viol[E_DATA]   = stb_pending && lnk_stb && (lnk_data != h_data);
    viol[E_NOWAIT] = h_arm && lnk_stb;
  end
endmodule

// File: rtl/hs_mon_sticky.sv
module hs_mon_sticky
  import hs_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_vec_t set,
  output err_vec_t flags
);
  err_vec_t flags_d;

  always_comb begin
    flags_d = flags | set;
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= flags_d[i];
      end
    end
  end
endmodule

// File: rtl/hs_mon_xfer_cnt.sv
module hs_mon_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lnk_rst,
  input  logic             lnk_stb,
  input  logic             lnk_ack,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic             inc;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    inc   = lnk_stb && lnk_ack && !lnk_rst;
    cnt_d = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_rst,
  input  logic [DATA_W-1:0] lnk_data,
  input  logic              lnk_stb,
  input  logic              lnk_ack,
  output logic [ERR_N-1:0]  err_flags,
  output logic              err_any,
  output logic [CNT_W-1:0]  xfer_cnt
);
  logic              h_rst;
  logic              h_stb;
  logic              h_ack;
  logic              h_arm;
  logic [DATA_W-1:0] h_data;
  err_vec_t          viol;
  err_vec_t          flags;

  hs_mon_history #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .lnk_rst(lnk_rst), .lnk_data(lnk_data),
    .lnk_stb(lnk_stb), .lnk_ack(lnk_ack), .h_rst(h_rst), .h_stb(h_stb),
    .h_ack(h_ack), .h_arm(h_arm), .h_data(h_data)
  );

  hs_mon_rules #(.DATA_W(DATA_W)) u_rules (
    .lnk_stb(lnk_stb), .lnk_ack(lnk_ack), .lnk_data(lnk_data),
    .h_rst(h_rst), .h_stb(h_stb), .h_ack(h_ack), .h_arm(h_arm),
    .h_data(h_data), .viol(viol)
  );

  hs_mon_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set(viol), .flags(flags)
  );

  hs_mon_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .lnk_rst(lnk_rst), .lnk_stb(lnk_stb),
    .lnk_ack(lnk_ack), .cnt(xfer_cnt)
  );

  always_comb begin
    err_flags = flags;
    err_any   = |flags;
  end
endmodule

// File: rtl/hs_link_monitor_chk.sv
module hs_link_monitor_chk
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lnk_rst,
  input logic [DATA_W-1:0] lnk_data,
  input logic              lnk_stb,
  input logic              lnk_ack,
  input logic [ERR_N-1:0]  err_flags,
  input logic              err_any,
  input logic [CNT_W-1:0]  xfer_cnt
);
  for (genvar i = 0; i < ERR_N; i++) begin : g_keep
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flags[i] |=> err_flags[i]); // R8
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_stb && lnk_ack && !lnk_rst) |=> (xfer_cnt == $past(xfer_cnt) + CNT_W'(1))); // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_stb && lnk_ack && !lnk_rst) |=> $stable(xfer_cnt)); // R6

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_RST]) |-> ($past(lnk_rst, 2) && $past(lnk_stb || lnk_ack))); // R1

  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_STB]) |-> $past(!lnk_stb)); // R2

  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_ACK]) |-> $past(!lnk_ack)); // R3

  AST_DATA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_DATA]) |-> ($past(lnk_stb) && $past(lnk_stb, 2))); // R4

  AST_NOWAIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_NOWAIT]) |-> ($past(lnk_stb) && !$past(lnk_stb, 2))); // R7
endmodule

bind hs_link_monitor hs_link_monitor_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lnk_rst(lnk_rst), .lnk_data(lnk_data),
  .lnk_stb(lnk_stb), .lnk_ack(lnk_ack), .err_flags(err_flags),
  .err_any(err_any), .xfer_cnt(xfer_cnt)
);

// File: tb/sim_hs_link_monitor.sv
module sim_hs_link_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int LIMIT = 200000;

  logic          clk;
  logic          rst_n;
  logic          lnk_rst;
  logic [DW-1:0] lnk_data;
  logic          lnk_stb;
  logic          lnk_ack;
  logic [4:0]    err_flags;
  logic          err_any;
  logic [CW-1:0] xfer_cnt;

  int checks = 0;
  int fails  = 0;

  hs_link_monitor #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .lnk_rst(lnk_rst), .lnk_data(lnk_data),
    .lnk_stb(lnk_stb), .lnk_ack(lnk_ack), .err_flags(err_flags),
    .err_any(err_any), .xfer_cnt(xfer_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected-value model built from the requirement text.
  logic          m_prst, m_pstb, m_pack, m_arm;
  logic [DW-1:0] m_pdat;
  logic [4:0]    m_err;
  logic [CW-1:0] m_cnt;

  function automatic logic [4:0] exp_viol(input logic prst, input logic pstb,
      input logic pack, input logic arm, input logic [DW-1:0] pdat,
      input logic s, input logic a, input logic [DW-1:0] d);
    logic [4:0] v;
    v = '0;
    v[0] = prst && (s || a);                                  // R1
    v[1] = !prst && pstb && !pack && !s;                      // R2
    v[2] = !prst && pack && !pstb && !a;                      // R3
    v[3] = !prst && pstb && !pack && s && (d != pdat);        // R4
    v[4] = arm && s;                                          // R7
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prst <= 1'b0; m_pstb <= 1'b0; m_pack <= 1'b0; m_arm <= 1'b0;
      m_pdat <= '0; m_err <= '0; m_cnt <= '0;
    end else begin
      m_err  <= m_err | exp_viol(m_prst, m_pstb, m_pack, m_arm, m_pdat,
                                 lnk_stb, lnk_ack, lnk_data);
      if (lnk_stb && lnk_ack && !lnk_rst) m_cnt <= m_cnt + 1'b1;
      m_arm  <= !lnk_rst && lnk_ack && !m_pack && !lnk_stb;
      m_prst <= lnk_rst;
      m_pstb <= lnk_stb;
      m_pack <= lnk_ack;
      m_pdat <= lnk_data;
    end
  end

  task automatic check_model(input string tag);
    checks++;
    if (err_flags !== m_err || err_any !== (|m_err) || xfer_cnt !== m_cnt) begin
      fails++;
      $display("FAIL %s flags=%b any=%b cnt=%0d expected flags=%b any=%b cnt=%0d",
               tag, err_flags, err_any, xfer_cnt, m_err, |m_err, m_cnt);
    end
  endtask

  task automatic check_exact(input string tag, input logic [4:0] ef, input logic [CW-1:0] ec);
    checks++;
    if (err_flags !== ef || err_any !== (|ef) || xfer_cnt !== ec) begin
      fails++;
      $display("FAIL %s flags=%b any=%b cnt=%0d expected flags=%b any=%b cnt=%0d",
               tag, err_flags, err_any, xfer_cnt, ef, |ef, ec);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic [DW-1:0] d,
                      input logic lr, input string tag);
    lnk_stb = s; lnk_ack = a; lnk_data = d; lnk_rst = lr;
    @(posedge clk);
    @(negedge clk);
    check_model(tag);
  endtask

  task automatic mon_reset();
    lnk_stb = 1'b0; lnk_ack = 1'b0; lnk_data = '0; lnk_rst = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * LIMIT);
    fails++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic g_stb, g_ack, g_rst;
    logic [DW-1:0] g_dat;
    void'($urandom(32'h1d5e_ed07));
    rst_n = 1'b1;
    @(negedge clk);
    mon_reset();
    check_exact("R9 reset state", 5'b0, '0);

    // R6: back-to-back transfers and one after a transmitter wait
    step(1, 1, 8'h11, 0, "R6 b2b 1");
    step(1, 1, 8'h12, 0, "R6 b2b 2");
    step(1, 1, 8'h13, 0, "R6 b2b 3");
    check_exact("R6 three consecutive transfers", 5'b0, 8'd3);
    step(0, 1, 8'h00, 0, "R6 rx waits");
    step(0, 1, 8'h00, 0, "R6 rx waits");
    step(1, 1, 8'h20, 0, "R6 after wait");
    check_exact("R6 four transfers", 5'b0, 8'd4);
    // R10 and R5: drop both after a transfer, payload churn with strobe low
    step(0, 0, 8'h21, 0, "R10 drop after transfer");
    step(0, 0, 8'h55, 0, "R5 idle payload");
    step(0, 0, 8'hAA, 0, "R5 idle payload");
    step(1, 0, 8'h30, 0, "R5 strobe up");
    step(1, 1, 8'h30, 0, "R5 transfer");
    step(1, 0, 8'h31, 0, "R5 new word after transfer");
    step(1, 1, 8'h31, 0, "R5 transfer");
    check_exact("R10 R5 no flag on legal traffic", 5'b0, 8'd6);

    mon_reset();
    step(0, 0, 8'h00, 1, "R1 link reset");
    step(1, 0, 8'h00, 0, "R1 strobe after reset");
    check_exact("R1 reset violation", 5'b00001, 8'd0);
    step(1, 1, 8'h00, 0, "R8 sticky");
    step(0, 0, 8'h00, 0, "R8 sticky");
    check_exact("R8 flag stays set", 5'b00001, 8'd1);
    mon_reset();
    check_exact("R8 cleared by monitor reset", 5'b0, 8'd0);

    step(1, 0, 8'h40, 0, "R2 strobe up");
    step(0, 0, 8'h40, 0, "R2 strobe dropped");
    check_exact("R2 strobe violation", 5'b00010, 8'd0);

    mon_reset();
    step(0, 1, 8'h00, 0, "R3 ack up");
    step(0, 0, 8'h00, 0, "R3 ack dropped");
    check_exact("R3 ack violation", 5'b00100, 8'd0);

    mon_reset();
    step(1, 0, 8'h05, 0, "R4 strobe up");
    step(1, 0, 8'h06, 0, "R4 payload changed");
    check_exact("R4 payload violation", 5'b01000, 8'd0);

    mon_reset();
    step(0, 1, 8'h00, 0, "R7 ack first");
    step(1, 1, 8'h07, 0, "R7 strobe next");
    check_exact("R7 waited for ack", 5'b10000, 8'd1);

    mon_reset();
    step(0, 1, 8'h00, 0, "R7 ack first");
    step(0, 1, 8'h00, 0, "R7 ack held");
    step(1, 1, 8'h07, 0, "R7 strobe later");
    check_exact("R7 later strobe is legal", 5'b00000, 8'd1);

    // Random traffic, mostly following the handshake
    for (int ep = 0; ep < 24; ep++) begin
      mon_reset();
      g_stb = 0; g_ack = 0; g_rst = 0; g_dat = '0;
      for (int c = 0; c < 120; c++) begin
        logic hold_s, hold_a;
        hold_s = g_stb && !g_ack && !g_rst;
        hold_a = g_ack && !g_stb && !g_rst;
        if (g_rst) begin
          g_stb = ($urandom_range(99) < 4);
          g_ack = ($urandom_range(99) < 4);
        end else begin
          g_stb = hold_s ? ($urandom_range(99) >= 3) : ($urandom_range(99) < 50);
          g_ack = hold_a ? ($urandom_range(99) >= 3) : ($urandom_range(99) < 45);
        end
        if (!(hold_s && $urandom_range(99) >= 3)) g_dat = DW'($urandom);
        g_rst = ($urandom_range(99) < 3);
        step(g_stb, g_ack, g_dat, g_rst, "R1 R2 R3 R4 R6 R7 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule